// File: doc/BRIEF.md
# Serial DAC Command Link Controller

This block drives a multi-channel serial digital-to-analog converter on behalf of a host. The host hands over a 24-bit command word and an update-all-channels flag through a valid/ready handshake. The controller then does the rest on its own. It pulls the active-low frame line down and shifts the word out most significant bit first on a divided serial clock. It closes the frame, waits the settling gap that matches the update kind, and drops the active-low load strobe for a short pulse. It holds off the next word until a guard time after that pulse has run out.

A separate clear request produces an active-low clear pulse. A request that arrives while a frame or its load sequence is in progress is held, and is issued only once that sequence has ended. When the readback option is enabled, the controller samples the converter's serial output on every serial-clock falling edge. At the end of the frame it presents the captured 24-bit word with a one-cycle valid pulse.

Every minimum time is a parameter in nanoseconds next to the system clock period. Each one is turned into whole clock cycles by rounding up.

Top module: `dac_link_ctrl`

## Requirements
- R1: Each frame (frame_n low) carries exactly 24 serial-clock falling edges. ser_dout at the k-th falling edge is bit 24-k of the accepted word, so the MSB goes first. frame_n rises only after the 24th falling edge.
- R2: With readback enabled, ser_clk stays high for at least 25 ns. Otherwise it stays high for at least 13 ns. It stays low for at least 13 ns, and consecutive falling edges are at least 33 ns apart.
- R3: frame_n falls at least 13 ns before the first falling edge of ser_clk. It rises at least 13 ns after the 24th falling edge.
- R4: frame_n stays high for at least 90 ns between two frames.
- R5: Inside a frame, ser_dout changes only together with a rising edge of ser_clk. It is therefore stable across every falling edge.
- R6: The time from frame_n rising to load_n falling is 1700 ns when in_all was 1 for that word, and 480 ns when in_all was 0. Each value is rounded up to whole clock cycles.
- R7: load_n stays low for at least 10 ns. At least 170 ns pass from a load_n falling edge to the next frame_n rising edge.
- R8: A one-cycle clr_req produces one clear_n low pulse of at least 10 ns, issued only while frame_n and load_n are high. A request made during a frame is deferred, so clear_n falls at least 170 ns after that frame's load_n falling edge.
- R9: A word is taken only in a cycle where in_valid and in_ready are both 1. in_ready is 0 from that cycle until at least 170 ns after the resulting load_n falling edge, and is 0 throughout every frame.
- R10: With readback enabled, rb_valid pulses for one cycle after each frame. At that point rb_word holds the 24 ser_din values sampled at the falling edges, first sample in bit 23.
- R11: After reset, frame_n, ser_clk, load_n and clear_n are 1, rb_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a command word |
| in_ready | output | 1 | Controller can take a command word |
| in_word | input | 24 | Command word to send, MSB first |
| in_all | input | 1 | Word updates all channels (selects the long settling gap) |
| clr_req | input | 1 | Request for a clear pulse |
| ser_clk | output | 1 | Serial clock to the converter, idles high |
| frame_n | output | 1 | Active-low frame strobe |
| ser_dout | output | 1 | Serial data to the converter |
| ser_din | input | 1 | Serial readback data from the converter |
| load_n | output | 1 | Active-low load strobe |
| clear_n | output | 1 | Active-low clear strobe |
| rb_valid | output | 1 | One-cycle pulse: readback word is complete |
| rb_word | output | 24 | Captured readback word |

## Verification
The bench measures every edge of the serial bus against the nanosecond limits, so a divider or lead-in count that is one short shows up at once as a phase or setup violation. It sends words with both settings of the update flag and checks the exact gap. A design that swapped or merged the two gaps would fail the 480 ns or 1700 ns comparison. It raises a clear request in the middle of a frame. A design that issued the clear pulse at once would pull clear_n low while frame_n is low, or before the load guard has run out. It compares the received and readback words bit for bit, which catches LSB-first shifting, data moving on the wrong clock edge, and an off-by-one bit count.

// File: rtl/dac_link_pkg.sv
package dac_link_pkg;

    localparam int FRAME_BITS = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_TAIL,
        ST_GAP,
        ST_LOAD,
        ST_GUARD,
        ST_CLEAR
    } seq_state_e;

    typedef struct packed {
        logic                  all_ch;
        logic [FRAME_BITS-1:0] word;
    } dac_cmd_t;

    // nanoseconds to whole clock cycles, rounded up
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_wait_timer.sv
module dac_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] value,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
    parameter int W     = 24,
    parameter int CW    = 8,
    parameter int LEAD  = 4,
    parameter int HI    = 4,
    parameter int LO    = 4,
    parameter bit RB_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] word,
    input  logic         release_i,
    input  logic         sdo_i,
    output logic         sclk,
    output logic         sdi,
    output logic         done,
    output logic         rb_valid,
    output logic [W-1:0] rb_word
);
    localparam int BW = $clog2(W + 1);

    logic          active_q;
    logic          sclk_q;
    logic [W-1:0]  sh_q;
    logic [BW-1:0] nfall_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          fall_now;
    logic          last_now;

    assign fall_now = active_q && (cnt_q == '0) && sclk_q;
    assign last_now = fall_now && (nfall_q == BW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b1;
            sh_q     <= '0;
            nfall_q  <= '0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last_now;
            if (start) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b1;
                sh_q     <= word;
                nfall_q  <= '0;
                cnt_q    <= CW'(LEAD - 1);
            end else if (active_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (sclk_q) begin
                    // falling edge: the converter samples here
                    sclk_q  <= 1'b0;
                    nfall_q <= nfall_q + 1'b1;
                    cnt_q   <= CW'(LO - 1);
                    if (last_now) begin
                        active_q <= 1'b0;
                    end
                end else begin
                    // rising edge: next bit goes out
                    sclk_q <= 1'b1;
                    sh_q   <= {sh_q[W-2:0], 1'b0};
                    cnt_q  <= CW'(HI - 1);
                end
            end else if (release_i) begin
                sclk_q <= 1'b1;
            end
        end
    end

    assign sclk = sclk_q;
    assign sdi  = sh_q[W-1];
    assign done = done_q;

    generate
        if (RB_EN) begin : g_rb
            logic [W-1:0] rb_q;
            logic         rbv_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    rb_q  <= '0;
                    rbv_q <= 1'b0;
                end else begin
                    rbv_q <= last_now;
                    if (fall_now) begin
                        rb_q <= {rb_q[W-2:0], sdo_i};
                    end
                end
            end
            assign rb_valid = rbv_q;
            assign rb_word  = rb_q;
        end else begin : g_no_rb
            assign rb_valid = 1'b0;
            assign rb_word  = '0;
        end
    endgenerate
endmodule

// File: rtl/dac_link_ctrl.sv
module dac_link_ctrl
    import dac_link_pkg::*;
#(
    parameter int CLK_NS           = 4,
    parameter int T_CLK_HIGH_NS    = 13,
    parameter int T_CLK_LOW_NS     = 13,
    parameter int T_CLK_PERIOD_NS  = 33,
    parameter int T_DATA_SETUP_NS  = 2,
    parameter int T_DATA_HOLD_NS   = 5,
    parameter int T_FRM_LEAD_NS    = 13,
    parameter int T_FRM_TAIL_NS    = 13,
    parameter int T_FRM_HIGH_NS    = 90,
    parameter int T_GAP_ALL_NS     = 1700,
    parameter int T_GAP_ONE_NS     = 480,
    parameter int T_LOAD_LOW_NS    = 10,
    parameter int T_CLEAR_LOW_NS   = 10,
    parameter int T_LOAD_GUARD_NS  = 170,
    parameter int T_RB_VALID_NS    = 25,
    parameter bit RB_EN            = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [FRAME_BITS-1:0] in_word,
    input  logic                  in_all,
    input  logic                  clr_req,
    output logic                  ser_clk,
    output logic                  frame_n,
    output logic                  ser_dout,
    input  logic                  ser_din,
    output logic                  load_n,
    output logic                  clear_n,
    output logic                  rb_valid,
    output logic [FRAME_BITS-1:0] rb_word
);
    // ---------------- derived cycle counts ----------------
    localparam int C_HI   = imax(imax(ns2cyc(T_CLK_HIGH_NS, CLK_NS), ns2cyc(T_DATA_SETUP_NS, CLK_NS)),
                                 RB_EN ? ns2cyc(T_RB_VALID_NS, CLK_NS) : 1);
    localparam int C_LO   = imax(imax(ns2cyc(T_CLK_LOW_NS, CLK_NS), ns2cyc(T_DATA_HOLD_NS, CLK_NS)),
                                 ns2cyc(T_CLK_PERIOD_NS, CLK_NS) - C_HI);
    localparam int C_LEAD = imax(ns2cyc(T_FRM_LEAD_NS, CLK_NS), C_HI);
    localparam int C_TAIL = imax(ns2cyc(T_FRM_TAIL_NS, CLK_NS), 2);
    localparam int C_FHI  = imax(ns2cyc(T_FRM_HIGH_NS, CLK_NS), 1);
    localparam int C_GALL = imax(ns2cyc(T_GAP_ALL_NS, CLK_NS), 1);
    localparam int C_GONE = imax(ns2cyc(T_GAP_ONE_NS, CLK_NS), 1);
    localparam int C_LDLO = imax(ns2cyc(T_LOAD_LOW_NS, CLK_NS), 1);
    localparam int C_CLLO = imax(ns2cyc(T_CLEAR_LOW_NS, CLK_NS), 1);
    localparam int C_GRD  = imax(ns2cyc(T_LOAD_GUARD_NS, CLK_NS) - C_LDLO, 1);
    localparam int C_MAXV = imax(imax(imax(C_GALL, C_GONE), imax(C_GRD, C_FHI)),
                                 imax(imax(C_LEAD, C_HI), imax(C_LO, C_TAIL)));
    localparam int CW     = $clog2(C_MAXV + 1);

    // ---------------- state ----------------
    seq_state_e    state_q;
    logic          all_q;
    logic          frame_n_q;
    logic          load_n_q;
    logic          clear_n_q;
    logic          clr_pend_q;

    dac_cmd_t      cmd_in;
    logic          accept;
    logic          frame_rise;
    logic          shift_done;
    logic          ph_load;
    logic [CW-1:0] ph_val;
    logic          ph_zero;
    logic          fh_zero;

    assign cmd_in     = '{all_ch: in_all, word: in_word};
    assign in_ready   = (state_q == ST_IDLE) && fh_zero && !clr_pend_q;
    assign accept     = in_valid && in_ready;
    assign frame_rise = (state_q == ST_TAIL) && ph_zero;

    // phase timer reload for the state being entered
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_IDLE: if (clr_pend_q) begin
                ph_load = 1'b1;
                ph_val  = CW'(C_CLLO - 1);
            end
            ST_FRAME: if (shift_done) begin
                ph_load = 1'b1;
                ph_val  = CW'(C_TAIL - 2);
            end
            ST_TAIL: if (ph_zero) begin
                ph_load = 1'b1;
                ph_val  = all_q ? CW'(C_GALL - 1) : CW'(C_GONE - 1);
            end
            ST_GAP: if (ph_zero) begin
                ph_load = 1'b1;
                ph_val  = CW'(C_LDLO - 1);
            end
            ST_LOAD: if (ph_zero) begin
                ph_load = 1'b1;
                ph_val  = CW'(C_GRD - 1);
            end
            default: begin
                ph_load = 1'b0;
                ph_val  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            all_q      <= 1'b0;
            frame_n_q  <= 1'b1;
            load_n_q   <= 1'b1;
            clear_n_q  <= 1'b1;
            clr_pend_q <= 1'b0;
        end else begin
            clr_pend_q <= clr_pend_q | clr_req;
            unique case (state_q)
                ST_IDLE: begin
                    if (clr_pend_q) begin
                        clear_n_q  <= 1'b0;
                        clr_pend_q <= clr_req;
                        state_q    <= ST_CLEAR;
                    end else if (accept) begin
                        frame_n_q <= 1'b0;
                        all_q     <= cmd_in.all_ch;
                        state_q   <= ST_FRAME;
                    end
                end
                ST_FRAME: if (shift_done) state_q <= ST_TAIL;
                ST_TAIL: if (ph_zero) begin
                    frame_n_q <= 1'b1;
                    state_q   <= ST_GAP;
                end
                ST_GAP: if (ph_zero) begin
                    load_n_q <= 1'b0;
                    state_q  <= ST_LOAD;
                end
                ST_LOAD: if (ph_zero) begin
                    load_n_q <= 1'b1;
                    state_q  <= ST_GUARD;
                end
                ST_GUARD: if (ph_zero) state_q <= ST_IDLE;
                ST_CLEAR: if (ph_zero) begin
                    clear_n_q <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- sub-blocks ----------------
    dac_wait_timer #(.CW(CW)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .load    (ph_load),
        .value   (ph_val),
        .expired (ph_zero)
    );

    dac_wait_timer #(.CW(CW)) u_frame_high (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_rise),
        .value   (CW'(C_FHI - 1)),
        .expired (fh_zero)
    );

    dac_frame_shifter #(
        .W     (FRAME_BITS),
        .CW    (CW),
        .LEAD  (C_LEAD),
        .HI    (C_HI),
        .LO    (C_LO),
        .RB_EN (RB_EN)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && !clr_pend_q),
        .word      (cmd_in.word),
        .release_i (frame_rise),
        .sdo_i     (ser_din),
        .sclk      (ser_clk),
        .sdi       (ser_dout),
        .done      (shift_done),
        .rb_valid  (rb_valid),
        .rb_word   (rb_word)
    );

    assign frame_n = frame_n_q;
    assign load_n  = load_n_q;
    assign clear_n = clear_n_q;
endmodule

// File: rtl/dac_link_chk.sv
module dac_link_chk (
    input logic clk,
    input logic rst,
    input logic ser_clk,
    input logic frame_n,
    input logic ser_dout,
    input logic load_n,
    input logic clear_n,
    input logic in_ready,
    input logic rb_valid
);
    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frame_n && ser_clk && load_n && clear_n && in_ready && !rb_valid));

    p_rise_after_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> !$past(ser_clk));

    p_dout_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (!frame_n && !$past(frame_n) && (ser_dout != $past(ser_dout))) |-> (ser_clk && !$past(ser_clk)));

    p_load_outside_frame_r7: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> frame_n);

    p_clear_alone_r8: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (frame_n && load_n));

    p_busy_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> !in_ready);

    p_rb_single_r10: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> !rb_valid);
endmodule

bind dac_link_ctrl dac_link_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .frame_n  (frame_n),
    .ser_dout (ser_dout),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .in_ready (in_ready),
    .rb_valid (rb_valid)
);

// File: tb/sim_dac_link_ctrl.sv
module sim_dac_link_ctrl;
    localparam int PER_NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_word = '0;
    logic        in_all = 1'b0;
    logic        clr_req = 1'b0;
    logic        ser_clk, frame_n, ser_dout, load_n, clear_n, rb_valid;
    logic        ser_din = 1'b0;
    logic [23:0] rb_word;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dac_link_ctrl u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_all(in_all), .clr_req(clr_req),
        .ser_clk(ser_clk), .frame_n(frame_n), .ser_dout(ser_dout),
        .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n),
        .rb_valid(rb_valid), .rb_word(rb_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ceil_ns(input int ns);
        return ((ns + PER_NS - 1) / PER_NS) * PER_NS;
    endfunction

    // ---------------- bus monitor and converter model ----------------
    int cyc = 0;
    logic p_clk = 1, p_frm = 1, p_dout = 0, p_load = 1, p_clr = 1;
    int t_frm_fall = 0, t_frm_rise = 0, t_last_fall = 0, t_last_rise = 0;
    int t_load_fall = 0, t_clr_fall = 0;
    bit seen_frm_rise = 0, seen_load = 0;
    int nbits = 0, frames = 0, clr_pulses = 0, rb_cnt = 0, pidx = 0, last_gap = 0;
    logic [23:0] rx = '0, last_rx = '0, dac_pat = '0, rb_cap = '0;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (p_frm && !frame_n) begin
                    if (seen_frm_rise)
                        chk((cyc - t_frm_rise) * PER_NS >= 90, "R4", "frame high ns", (cyc - t_frm_rise) * PER_NS, 90);
                    t_frm_fall = cyc; nbits = 0; rx = '0;
                    ser_din = dac_pat[23]; pidx = 22;
                end
                if (!frame_n && p_clk && !ser_clk) begin
                    nbits++;
                    rx = {rx[22:0], ser_dout};
                    if (nbits == 1)
                        chk((cyc - t_frm_fall) * PER_NS >= 25, "R3", "lead before first fall ns", (cyc - t_frm_fall) * PER_NS, 25);
                    else begin
                        chk((cyc - t_last_rise) * PER_NS >= 25, "R2", "clock high ns", (cyc - t_last_rise) * PER_NS, 25);
                        chk((cyc - t_last_fall) * PER_NS >= 33, "R2", "fall to fall ns", (cyc - t_last_fall) * PER_NS, 33);
                    end
                    t_last_fall = cyc;
                end
                if (!frame_n && !p_clk && ser_clk) begin
                    chk((cyc - t_last_fall) * PER_NS >= 13, "R2", "clock low ns", (cyc - t_last_fall) * PER_NS, 13);
                    t_last_rise = cyc;
                    if (pidx >= 0) begin
                        ser_din = dac_pat[pidx];
                        pidx--;
                    end
                end
                if (!frame_n && !p_frm && (ser_dout != p_dout))
                    chk(!p_clk && ser_clk, "R5", "data moved without rising clock", ser_clk, 1);
                if (!frame_n)
                    chk(!in_ready, "R9", "ready inside frame", in_ready, 0);
                if (!p_frm && frame_n) begin
                    chk(nbits == 24, "R1", "falling edges in frame", nbits, 24);
                    chk((cyc - t_last_fall) * PER_NS >= 13, "R3", "tail after last fall ns", (cyc - t_last_fall) * PER_NS, 13);
                    if (seen_load)
                        chk((cyc - t_load_fall) * PER_NS >= 170, "R7", "load fall to frame end ns", (cyc - t_load_fall) * PER_NS, 170);
                    last_rx = rx; frames++;
                    t_frm_rise = cyc; seen_frm_rise = 1;
                end
                if (p_load && !load_n) begin
                    last_gap = (cyc - t_frm_rise) * PER_NS;
                    t_load_fall = cyc; seen_load = 1;
                end
                if (!p_load && load_n)
                    chk((cyc - t_load_fall) * PER_NS >= 10, "R7", "load low ns", (cyc - t_load_fall) * PER_NS, 10);
                if (p_clr && !clear_n) begin
                    chk(frame_n && load_n, "R8", "clear while frame or load active", {frame_n, load_n}, 3);
                    t_clr_fall = cyc;
                end
                if (!p_clr && clear_n) begin
                    chk((cyc - t_clr_fall) * PER_NS >= 10, "R8", "clear low ns", (cyc - t_clr_fall) * PER_NS, 10);
                    clr_pulses++;
                end
                if (rb_valid) begin
                    rb_cap = rb_word;
                    rb_cnt++;
                end
            end
            p_clk = ser_clk; p_frm = frame_n; p_dout = ser_dout;
            p_load = load_n; p_clr = clear_n;
        end
    end

    // ---------------- scenario tasks ----------------
    task automatic offer(input logic [23:0] w, input logic a);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_all = a;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R9", "ready right after acceptance", in_ready, 0);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!in_ready);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(frame_n && ser_clk && load_n && clear_n, "R11", "idle strobes after reset",
            {frame_n, ser_clk, load_n, clear_n}, 15);
        chk(in_ready && !rb_valid, "R11", "ready/rb_valid after reset", {in_ready, rb_valid}, 2);
    endtask

    task automatic t_single(input logic [23:0] w, input logic [23:0] pat);
        int f0, r0;
        f0 = frames; r0 = rb_cnt; dac_pat = pat;
        offer(w, 1'b0);
        wait_idle();
        chk(frames == f0 + 1, "R9", "frames per handshake", frames - f0, 1);
        chk(last_rx == w, "R1", "word sent MSB first", last_rx, w);
        chk(last_gap == ceil_ns(480), "R6", "single-channel gap ns", last_gap, ceil_ns(480));
        chk(rb_cnt == r0 + 1, "R10", "readback pulses", rb_cnt - r0, 1);
        chk(rb_cap == pat, "R10", "readback word", rb_cap, pat);
        chk((cyc - t_load_fall) * PER_NS >= 170, "R9", "ready after load guard ns", (cyc - t_load_fall) * PER_NS, 170);
    endtask

    task automatic t_all(input logic [23:0] w);
        dac_pat = ~w;
        offer(w, 1'b1);
        wait_idle();
        chk(last_rx == w, "R1", "word sent MSB first (all)", last_rx, w);
        chk(last_gap == ceil_ns(1700), "R6", "all-channel gap ns", last_gap, ceil_ns(1700));
        chk(rb_cap == ~w, "R10", "readback word (all)", rb_cap, ~w);
    endtask

    task automatic t_clear_idle();
        int c0;
        c0 = clr_pulses;
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(clr_pulses == c0 + 1, "R8", "clear pulses from idle request", clr_pulses - c0, 1);
        chk(frames >= 0 && in_ready, "R8", "ready back after clear", in_ready, 1);
    endtask

    task automatic t_clear_in_frame(input logic [23:0] w);
        int c0;
        c0 = clr_pulses;
        dac_pat = 24'h0F0F0F;
        offer(w, 1'b0);
        while (frame_n) @(negedge clk);
        repeat (30) @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
        chk(clr_pulses == c0, "R8", "clear held during frame", clr_pulses - c0, 0);
        wait_idle();
        chk(clr_pulses == c0 + 1, "R8", "deferred clear issued once", clr_pulses - c0, 1);
        chk(t_clr_fall > t_load_fall && (t_clr_fall - t_load_fall) * PER_NS >= 170, "R8",
            "clear after load guard ns", (t_clr_fall - t_load_fall) * PER_NS, 170);
        chk(last_rx == w, "R1", "word intact with pending clear", last_rx, w);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog expired: got %0d expected %0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        t_reset();
        t_single(24'hA5C31E, 24'h3C96E1);
        t_single(24'h800001, 24'hFFFFFF);
        t_all(24'h5A0FF0);
        t_single(24'h000000, 24'h800001);
        t_clear_idle();
        t_clear_in_frame(24'hC0FFEE);
        t_all(24'hFFFFFF);
        t_single(24'h123456, 24'h654321);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule